// File: doc/BRIEF.md
# Chained Event Counter Bank

This block holds six general 32-bit event counters and one dedicated cycle counter. Each general counter carries a programmable 10-bit event type. It counts the hardware event pulse whose line number equals that type, a software increment aimed at it, or a chain event from its even-numbered partner, depending on the type. Counting needs both the global enable and the counter's own enable bit.

A counter that wraps to zero raises its own sticky bit in the overflow status vector. Counters 0, 2 and 4 then hand one chain event to counters 1, 3 and 5. The receiver counts that event only when it is enabled and typed for chaining. The lower half therefore shows its own overflow even when the chain is taken, and both halves of a pair can end up flagged.

The cycle counter advances once per clock while enabled. It is 32 or 64 bits wide for overflow purposes and never feeds a chain. Each counter can be loaded through a write port. Status bits clear through a write-one-to-clear port. An interrupt request is raised from the status bits that are masked in.

Top module: `evc_bank`

## Requirements
- R1: A synchronous reset clears all six general counters, the cycle counter and every overflow status bit, and holds `irq` low.
- R2: With `glb_en` and the counter's enable bit set, a general counter whose type t is nonzero and below 32 adds one in every cycle that `hw_evt[t]` is high.
- R3: A general counter stepping past 32'hFFFF_FFFF becomes zero and sets status bit i, where bit i belongs to counter i and bit 6 to the cycle counter.
- R4: When counter 0, 2 or 4 wraps, counter 1, 3 or 5 respectively adds one in the same cycle, provided it is enabled and typed 10'h01E. The lower counter's status bit is set as well, so both bits can be set.
- R5: A chain event leaves the receiver unchanged when the receiver is disabled or typed other than 10'h01E. A wrap of counter 1, 3 or 5 delivers no chain event to any counter.
- R6: While `glb_en` is low no counter changes except by a write. A counter whose enable bit is low ignores all of its event sources.
- R7: A cycle with `sw_inc_wr` high adds one to every counter that is selected in `sw_inc_mask`, enabled, and typed 10'h000. Such an increment wraps, flags and chains exactly like any other increment.
- R8: The enabled cycle counter adds one per clock. With `long_cyc` high it flags bit 6 only on a 64-bit wrap. With `long_cyc` low it flags bit 6 whenever its low 32 bits wrap, and its upper bits keep counting.
- R9: A counter typed 10'h01E that sees `hw_evt[30]` and a chain event in the same cycle adds two, and it flags if that sum wraps.
- R10: Status bits stay set until a cycle with `ovf_clr_wr` high and the matching `ovf_clr_mask` bit set. A new overflow in that same cycle keeps the bit set.
- R11: `irq` is high exactly when some status bit and its `irq_en` bit are both set.
- R12: `cnt_wr` loads `cnt_wr_data` into the counter selected by `cnt_wr_idx`: 0 to 5 take the low 32 bits, and 6 takes all 64 bits. In that cycle the write replaces any counting and raises no overflow for that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| glb_en | input | 1 | Global count enable |
| long_cyc | input | 1 | Cycle counter overflows at 64 bits when high |
| cnt_en | input | 7 | Per-counter enable, bit 6 is the cycle counter |
| irq_en | input | 7 | Interrupt mask per status bit |
| evt_types | input | 60 | Ten-bit event type per general counter, counter i at bits [10i+9:10i] |
| hw_evt | input | 32 | Hardware event pulses, line t serves type t |
| sw_inc_wr | input | 1 | Software increment strobe |
| sw_inc_mask | input | 6 | Counters targeted by the software increment |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wr_idx | input | 3 | Counter to load, 6 is the cycle counter |
| cnt_wr_data | input | 64 | Load value |
| ovf_clr_wr | input | 1 | Status clear strobe |
| ovf_clr_mask | input | 7 | Status bits to clear |
| cnt_vals | output | 192 | General counter values, counter i at bits [32i+31:32i] |
| cyc_val | output | 64 | Cycle counter value |
| ovf_status | output | 7 | Sticky overflow status |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle. The first is a hardware pulse on the chain-code event line and a chain event from the partner, aimed at the same counter. The bench preloads the lower counter to all ones, then raises event lines 5 and 30 together. It expects the upper counter to advance by two: once from a small start value and once from all ones, where it must wrap to one and flag. The second is a fresh overflow and a status clear on the same bit in one cycle, and the bench requires the bit to survive.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int GEN_N      = 6;
  localparam int CNT_W      = 32;
  localparam int CYC_W      = 64;
  localparam int TYPE_W     = 10;
  localparam int HW_EVT_N   = 32;
  localparam int SWINC_CODE = 'h000;
  localparam int CHAIN_CODE = 'h01E;

  // True when counter idx hands its wrap to idx+1.
  function automatic bit links_up(int idx, int gen_n);
    return ((idx % 2) == 0) && ((idx + 1) < gen_n);
  endfunction
endpackage

// File: rtl/evc_gen_ctr.sv
module evc_gen_ctr
  import evc_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int TW = TYPE_W,
  parameter int NE = HW_EVT_N,
  localparam int SELW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [TW-1:0] evt_type,
  input  logic [NE-1:0] hw_evt,
  input  logic          sw_pulse,
  input  logic          chain_in,
  input  logic          ld,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  value,
  output logic          wrap
);
  logic       hw_hit, sw_hit, ch_hit;
  logic [1:0] inc;
  logic [W:0] sum;

  // value plus a small step, with the carry out on top
  function automatic logic [W:0] add_carry(logic [W-1:0] v, logic [1:0] s);
    return {1'b0, v} + (W+1)'(s);
  endfunction

  always_comb begin
    hw_hit = 1'b0;
    if (active && (evt_type != TW'(SWINC_CODE)) && (evt_type < TW'(NE)))
      hw_hit = hw_evt[evt_type[SELW-1:0]];
    sw_hit = active && sw_pulse && (evt_type == TW'(SWINC_CODE));
    ch_hit = active && chain_in && (evt_type == TW'(CHAIN_CODE));
    inc    = {1'b0, hw_hit} + {1'b0, sw_hit} + {1'b0, ch_hit};
    sum    = add_carry(value, inc);
    wrap   = sum[W] && !ld;
  end

  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (ld) value <= ld_val;
    else         value <= sum[W-1:0];
  end
endmodule

// File: rtl/evc_cyc_ctr.sv
module evc_cyc_ctr
  import evc_pkg::*;
#(
  parameter int W  = CYC_W,
  parameter int NW = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         long_mode,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [W-1:0] nxt;
  logic         full_wrap, short_wrap;

  always_comb begin
    nxt        = value + W'(active);
    full_wrap  = active && (&value);
    short_wrap = active && (&value[NW-1:0]);
    wrap       = !ld && (long_mode ? full_wrap : short_wrap);
  end

  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (ld) value <= ld_val;
    else         value <= nxt;
  end
endmodule

// File: rtl/evc_ovf_stat.sv
module evc_ovf_stat #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  always_comb clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_eff) | set_vec;
  end

  assign irq = |(status & irq_en);
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_GEN  = GEN_N,
  parameter int GCNT_W   = CNT_W,
  parameter int CCNT_W   = CYC_W,
  parameter int ETYPE_W  = TYPE_W,
  parameter int NUM_EVT  = HW_EVT_N,
  localparam int NCTR    = NUM_GEN + 1,
  localparam int IDX_W   = $clog2(NCTR)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      glb_en,
  input  logic                      long_cyc,
  input  logic [NCTR-1:0]           cnt_en,
  input  logic [NCTR-1:0]           irq_en,
  input  logic [NUM_GEN*ETYPE_W-1:0] evt_types,
  input  logic [NUM_EVT-1:0]        hw_evt,
  input  logic                      sw_inc_wr,
  input  logic [NUM_GEN-1:0]        sw_inc_mask,
  input  logic                      cnt_wr,
  input  logic [IDX_W-1:0]          cnt_wr_idx,
  input  logic [CCNT_W-1:0]         cnt_wr_data,
  input  logic                      ovf_clr_wr,
  input  logic [NCTR-1:0]           ovf_clr_mask,
  output logic [NUM_GEN*GCNT_W-1:0] cnt_vals,
  output logic [CCNT_W-1:0]         cyc_val,
  output logic [NCTR-1:0]           ovf_status,
  output logic                      irq
);
  // wrap_vec: per-counter overflow this cycle; chain_in: chain event delivered
  logic [NCTR-1:0]    wrap_vec;
  logic [NUM_GEN-1:0] chain_in;
  logic               cyc_ld;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic ld_g;
    assign ld_g = cnt_wr && (cnt_wr_idx == IDX_W'(g));

    if ((g % 2 == 1) && links_up(g - 1, NUM_GEN)) begin : g_link
      assign chain_in[g] = wrap_vec[g-1];
    end else begin : g_head
      assign chain_in[g] = 1'b0;
    end

    evc_gen_ctr #(
      .W (GCNT_W),
      .TW(ETYPE_W),
      .NE(NUM_EVT)
    ) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .active  (glb_en && cnt_en[g]),
      .evt_type(evt_types[g*ETYPE_W +: ETYPE_W]),
      .hw_evt  (hw_evt),
      .sw_pulse(sw_inc_wr && sw_inc_mask[g]),
      .chain_in(chain_in[g]),
      .ld      (ld_g),
      .ld_val  (cnt_wr_data[GCNT_W-1:0]),
      .value   (cnt_vals[g*GCNT_W +: GCNT_W]),
      .wrap    (wrap_vec[g])
    );
  end

  assign cyc_ld = cnt_wr && (cnt_wr_idx == IDX_W'(NUM_GEN));

  evc_cyc_ctr #(
    .W (CCNT_W),
    .NW(GCNT_W)
  ) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .active   (glb_en && cnt_en[NUM_GEN]),
    .long_mode(long_cyc),
    .ld       (cyc_ld),
    .ld_val   (cnt_wr_data),
    .value    (cyc_val),
    .wrap     (wrap_vec[NUM_GEN])
  );

  evc_ovf_stat #(
    .N(NCTR)
  ) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (wrap_vec),
    .clr_wr  (ovf_clr_wr),
    .clr_mask(ovf_clr_mask),
    .irq_en  (irq_en),
    .status  (ovf_status),
    .irq     (irq)
  );
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
  import evc_pkg::*;
#(
  parameter int NUM_GEN = GEN_N,
  parameter int GCNT_W  = CNT_W,
  parameter int CCNT_W  = CYC_W,
  parameter int ETYPE_W = TYPE_W,
  localparam int NCTR   = NUM_GEN + 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       glb_en,
  input logic [NCTR-1:0]            cnt_en,
  input logic [NCTR-1:0]            irq_en,
  input logic [NUM_GEN*ETYPE_W-1:0] evt_types,
  input logic                       cnt_wr,
  input logic                       ovf_clr_wr,
  input logic [NCTR-1:0]            ovf_clr_mask,
  input logic [NUM_GEN*GCNT_W-1:0]  cnt_vals,
  input logic [CCNT_W-1:0]          cyc_val,
  input logic [NCTR-1:0]            ovf_status,
  input logic                       irq,
  input logic [NCTR-1:0]            wrap_vec,
  input logic [NUM_GEN-1:0]         chain_in
);
  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !cnt_wr) |=> ($stable(cnt_vals) && $stable(cyc_val)));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_status == '0) |-> !irq);

  for (genvar i = 0; i < NCTR; i++) begin : g_bit
    // R3
    ovf_sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
      wrap_vec[i] |=> ovf_status[i]);
    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_clr_wr && ovf_clr_mask[i] && !wrap_vec[i]) |=> !ovf_status[i]);
  end

  for (genvar g = 1; g < NUM_GEN; g += 2) begin : g_odd
    // R4
    chain_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (chain_in[g] && glb_en && cnt_en[g] && !cnt_wr &&
       (evt_types[g*ETYPE_W +: ETYPE_W] == ETYPE_W'(CHAIN_CODE)))
      |=> (cnt_vals[g*GCNT_W +: GCNT_W] != $past(cnt_vals[g*GCNT_W +: GCNT_W])));
    // R5
    chain_refused_chk: assert property (@(posedge clk) disable iff (rst)
      (chain_in[g] && !cnt_en[g] && !cnt_wr)
      |=> $stable(cnt_vals[g*GCNT_W +: GCNT_W]));
  end
endmodule

bind evc_bank evc_bank_chk #(
  .NUM_GEN(NUM_GEN),
  .GCNT_W (GCNT_W),
  .CCNT_W (CCNT_W),
  .ETYPE_W(ETYPE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .glb_en      (glb_en),
  .cnt_en      (cnt_en),
  .irq_en      (irq_en),
  .evt_types   (evt_types),
  .cnt_wr      (cnt_wr),
  .ovf_clr_wr  (ovf_clr_wr),
  .ovf_clr_mask(ovf_clr_mask),
  .cnt_vals    (cnt_vals),
  .cyc_val     (cyc_val),
  .ovf_status  (ovf_status),
  .irq         (irq),
  .wrap_vec    (wrap_vec),
  .chain_in    (chain_in)
);

// File: tb/evc_bank_tb.sv
module evc_bank_tb;
  logic         clk = 1'b0;
  logic         rst, glb_en, long_cyc;
  logic [6:0]   cnt_en, irq_en;
  logic [9:0]   ty [6];
  logic [59:0]  evt_types;
  logic [31:0]  hw_evt;
  logic         sw_inc_wr;
  logic [5:0]   sw_inc_mask;
  logic         cnt_wr;
  logic [2:0]   cnt_wr_idx;
  logic [63:0]  cnt_wr_data;
  logic         ovf_clr_wr;
  logic [6:0]   ovf_clr_mask;
  logic [191:0] cnt_vals;
  logic [63:0]  cyc_val;
  logic [6:0]   ovf_status;
  logic         irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 6; i++) evt_types[i*10 +: 10] = ty[i];

  evc_bank u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .long_cyc(long_cyc),
    .cnt_en(cnt_en), .irq_en(irq_en), .evt_types(evt_types), .hw_evt(hw_evt),
    .sw_inc_wr(sw_inc_wr), .sw_inc_mask(sw_inc_mask), .cnt_wr(cnt_wr),
    .cnt_wr_idx(cnt_wr_idx), .cnt_wr_data(cnt_wr_data), .ovf_clr_wr(ovf_clr_wr),
    .ovf_clr_mask(ovf_clr_mask), .cnt_vals(cnt_vals), .cyc_val(cyc_val),
    .ovf_status(ovf_status), .irq(irq)
  );

  // scoreboard: sel 0..5 counters, 6 cycle counter, 7 status, 8 irq
  typedef struct {
    string       tag;
    int          sel;
    logic [63:0] v;
  } item_t;
  item_t q[$];
  event  mon_ev;

  function automatic logic [63:0] observe(int sel);
    if (sel < 6)       return {32'h0, cnt_vals[sel*32 +: 32]};
    else if (sel == 6) return cyc_val;
    else if (sel == 7) return {57'h0, ovf_status};
    else               return {63'h0, irq};
  endfunction

  initial forever begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] got;
      it  = q.pop_front();
      got = observe(it.sel);
      n_vec++;
      if (got !== it.v) begin
        n_bad++;
        $display("FAIL %s sel=%0d got=%h exp=%h", it.tag, it.sel, got, it.v);
      end
    end
  end

  task automatic go();
    @(posedge clk);
    #2;
  endtask

  task automatic want(string tag, int sel, logic [63:0] v);
    q.push_back('{tag, sel, v});
  endtask

  task automatic flush();
    -> mon_ev;
    #1;
  endtask

  task automatic wr(int idx, logic [63:0] d);
    cnt_wr = 1'b1; cnt_wr_idx = 3'(idx); cnt_wr_data = d;
    go();
    cnt_wr = 1'b0;
  endtask

  task automatic clr(logic [6:0] m);
    ovf_clr_wr = 1'b1; ovf_clr_mask = m;
    go();
    ovf_clr_wr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // reset with every source busy
    rst = 1'b1; glb_en = 1'b1; long_cyc = 1'b0; cnt_en = '1; irq_en = '0;
    for (int i = 0; i < 6; i++) ty[i] = 10'd5;
    hw_evt = '1; sw_inc_wr = 1'b0; sw_inc_mask = '0; cnt_wr = 1'b0;
    cnt_wr_idx = '0; cnt_wr_data = '0; ovf_clr_wr = 1'b0; ovf_clr_mask = '0;
    go(); go();
    rst = 1'b0; cnt_en = '0; hw_evt = '0; irq_en = '1;
    go();
    for (int i = 0; i < 7; i++) want("R1", i, 64'h0);
    want("R1", 7, 64'h0); want("R1", 8, 64'h0);
    flush();
    irq_en = '0;

    // R2 / R6: counter 0 counts line 5, disabled counter 3 ignores it
    ty[0] = 10'd5; ty[3] = 10'd5; cnt_en = 7'b0000001; hw_evt = 32'h1 << 5;
    go(); go(); go();
    hw_evt = '0;
    want("R2", 0, 64'd3); want("R6", 3, 64'd0);
    flush();

    // R6: global enable low
    glb_en = 1'b0; hw_evt = 32'h1 << 5;
    go();
    want("R6", 0, 64'd3);
    flush();
    glb_en = 1'b1; hw_evt = '0;

    // R7: software increment hits only type 0x000 counters
    ty[1] = 10'h000; ty[2] = 10'h000; cnt_en = 7'b0000111;
    sw_inc_wr = 1'b1; sw_inc_mask = 6'b000111;
    go();
    sw_inc_wr = 1'b0;
    want("R7", 0, 64'd3); want("R7", 1, 64'd1); want("R7", 2, 64'd1);
    flush();

    // R12 load, then R3 / R4 wrap and chain
    wr(0, 64'hFFFF_FFFF);
    want("R12", 0, 64'hFFFF_FFFF);
    flush();
    ty[1] = 10'h01E; hw_evt = 32'h1 << 5;
    go();
    hw_evt = '0;
    want("R3", 0, 64'd0); want("R4", 1, 64'd2); want("R3", 7, 64'h01);
    want("R11", 8, 64'd0);
    flush();
    irq_en = 7'h01;
    go();
    want("R11", 8, 64'd1);
    flush();

    // R4: both halves wrap and both flag
    wr(1, 64'hFFFF_FFFF); wr(0, 64'hFFFF_FFFF);
    hw_evt = 32'h1 << 5;
    go();
    hw_evt = '0;
    want("R4", 0, 64'd0); want("R4", 1, 64'd0); want("R4", 7, 64'h03);
    flush();

    // R10: write-one-to-clear, set wins over clear
    clr(7'h01);
    want("R10", 7, 64'h02); want("R11", 8, 64'd0);
    flush();
    wr(0, 64'hFFFF_FFFF);
    hw_evt = 32'h1 << 5; ovf_clr_wr = 1'b1; ovf_clr_mask = 7'h01;
    go();
    hw_evt = '0; ovf_clr_wr = 1'b0;
    want("R10", 7, 64'h03); want("R4", 1, 64'd1);
    flush();
    clr(7'h7F);
    want("R10", 7, 64'h00);
    flush();

    // R5: neighbour disabled
    cnt_en = 7'b0000101;
    wr(0, 64'hFFFF_FFFF);
    hw_evt = 32'h1 << 5;
    go();
    hw_evt = '0;
    want("R5", 1, 64'd1); want("R5", 0, 64'd0); want("R5", 7, 64'h01);
    flush();
    // R5: neighbour typed otherwise
    cnt_en = 7'b0000111; ty[1] = 10'd7;
    wr(0, 64'hFFFF_FFFF);
    hw_evt = 32'h1 << 5;
    go();
    hw_evt = '0;
    want("R5", 1, 64'd1); want("R5", 7, 64'h01);
    flush();
    // R5: odd counter wrap feeds nobody
    ty[2] = 10'h01E; ty[1] = 10'd5;
    wr(1, 64'hFFFF_FFFF);
    hw_evt = 32'h1 << 5;
    go();
    hw_evt = '0;
    want("R5", 2, 64'd1); want("R3", 1, 64'd0); want("R5", 0, 64'd1);
    want("R5", 7, 64'h03);
    flush();
    clr(7'h7F);

    // R9: hardware line 30 and chain on the same counter
    ty[2] = 10'h000; ty[1] = 10'h01E; ty[0] = 10'd5;
    wr(1, 64'h10); wr(0, 64'hFFFF_FFFF);
    hw_evt = (32'h1 << 5) | (32'h1 << 30);
    go();
    hw_evt = '0;
    want("R9", 0, 64'd0); want("R9", 1, 64'h12); want("R9", 7, 64'h01);
    flush();
    wr(1, 64'hFFFF_FFFF); wr(0, 64'hFFFF_FFFF);
    hw_evt = (32'h1 << 5) | (32'h1 << 30);
    go();
    hw_evt = '0;
    want("R9", 1, 64'd1); want("R9", 7, 64'h03);
    flush();
    clr(7'h7F);
    want("R10", 7, 64'h00);
    flush();

    // R7: software increment wraps and chains
    ty[3] = 10'h01E; cnt_en = 7'b0001100;
    wr(2, 64'hFFFF_FFFF);
    sw_inc_wr = 1'b1; sw_inc_mask = 6'b000100;
    go();
    sw_inc_wr = 1'b0;
    want("R7", 2, 64'd0); want("R7", 3, 64'd1); want("R7", 7, 64'h04);
    flush();
    clr(7'h7F);

    // R8: cycle counter, short overflow
    cnt_en = 7'b1000000; long_cyc = 1'b0;
    wr(6, 64'h0000_0000_FFFF_FFFE);
    want("R12", 6, 64'h0000_0000_FFFF_FFFE);
    flush();
    go();
    want("R8", 6, 64'h0000_0000_FFFF_FFFF); want("R8", 7, 64'h00);
    flush();
    go();
    want("R8", 6, 64'h0000_0001_0000_0000); want("R8", 7, 64'h40);
    flush();
    cnt_en = '0;
    clr(7'h7F);
    // R8: long mode ignores a low-half wrap, flags the full wrap
    long_cyc = 1'b1; cnt_en = 7'b1000000;
    wr(6, 64'h0000_0000_FFFF_FFFF);
    go();
    want("R8", 6, 64'h0000_0001_0000_0000); want("R8", 7, 64'h00);
    flush();
    wr(6, 64'hFFFF_FFFF_FFFF_FFFF);
    go();
    want("R8", 6, 64'h0); want("R8", 7, 64'h40);
    flush();
    cnt_en = '0;
    clr(7'h7F);

    // R12: load beats counting and suppresses overflow
    cnt_en = 7'b0000001; ty[0] = 10'd5;
    wr(0, 64'hFFFF_FFFF);
    hw_evt = 32'h1 << 5;
    wr(0, 64'h100);
    hw_evt = '0;
    want("R12", 0, 64'h100); want("R12", 7, 64'h00); want("R11", 8, 64'd0);
    flush();

    go();
    done = 1;
    summary();
    $finish;
  end
endmodule